// File: doc/BRIEF.md
# Fail-Safe Clock Monitor and Switcher

This block supervises an external oscillator with a slow sample clock from a low-frequency internal oscillator. It drives the select of a glitch-free clock mux that chooses between the external clock and an internal oscillator. When the external clock stops, the block moves the system onto the internal oscillator. It then holds a latched fail-safe condition and sets a sticky failure flag. Software clears the condition and the flag in a fixed order.

The block also runs the oscillator start-up. In the crystal-type modes the system runs from the internal oscillator while a start-up timer counts external oscillator edges. The system then switches to the external clock and monitoring begins. In the external-clock and RC modes monitoring begins straight after reset or wake-up. All logic runs in one fast reference clock domain. The external and sample clocks arrive as plain levels and pass through two-flop synchronizers with edge detection.

Top module: `fscm_top`

## Requirements
- R1: During and after synchronous reset, the outputs are `use_int`=1, `failsafe`=0, `fail_flag`=0 and `stable`=0, and `int_freq` takes its reset code 6.
- R2: With `osc_mode` 0, 1 or 2 (low-power, crystal, high-speed crystal), `stable` rises only after STARTUP_CYCLES rising edges of the external clock. `use_int` stays 1 until then and drops to 0 afterwards when the select bit is 0.
- R3: With `osc_mode` 3 (external clock), 4 (RC) or any higher code, `stable` rises within two cycles of leaving reset or sleep, and monitoring starts at once.
- R4: Once `stable` is 1, an external clock that keeps toggling between sample edges causes no failure. An external clock that stops sets `failsafe` and `fail_flag` within two sample-clock periods plus synchronizer latency.
- R5: `failsafe` clears only on reset, on `sleep_enter`, or on a `sel_wr` whose data differs from the current select bit. A `sel_wr` with the same value leaves it set.
- R6: `freq_wr` loads `freq_wdata` into `int_freq` at any time and leaves `failsafe` unchanged.
- R7: `flag_clr` has no effect while `failsafe` is 1. When `failsafe` is 0 it clears `fail_flag` on the next cycle.
- R8: `sleep_enter` clears `stable` and stops monitoring until `wake`. In the crystal-type modes, start-up must complete again after wake-up.
- R9: Whenever `failsafe` is 1 or the select bit is 1, `use_int` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock for all logic |
| rst | input | 1 | Synchronous active-high reset |
| osc_mode | input | 3 | Oscillator mode code (0-2 crystal-type, 3 external, 4 RC) |
| ext_clk | input | 1 | External oscillator level |
| smp_clk | input | 1 | Low-frequency sample clock level |
| sleep_enter | input | 1 | Pulse: enter sleep |
| wake | input | 1 | Pulse: leave sleep |
| sel_wr | input | 1 | Pulse: write clock-source select bit |
| sel_wdata | input | 1 | Select data, 1 forces the internal oscillator |
| freq_wr | input | 1 | Pulse: write internal oscillator frequency code |
| freq_wdata | input | 3 | Frequency code data |
| flag_clr | input | 1 | Pulse: request to clear the failure flag |
| use_int | output | 1 | Clock mux select, 1 selects the internal oscillator |
| failsafe | output | 1 | Fail-safe condition active |
| fail_flag | output | 1 | Sticky failure flag |
| stable | output | 1 | Start-up and clock switchover complete |
| int_freq | output | 3 | Current internal oscillator frequency code |

## Verification
The properties assume that the control inputs are single-cycle pulses sampled on the reference clock. They also assume that both oscillator levels stay high and low for at least two reference cycles, so that the synchronizers see every edge. The bench drives the pulses from tasks at the falling edge of the reference clock. It toggles the external level every three cycles and the sample level every forty, so a running external clock always fits many edges into one sample period. A failure is produced only by stopping the external clock outright.

// File: rtl/fscm_pkg.sv
package fscm_pkg;
  typedef enum logic [2:0] {
    OSC_LP = 3'd0,
    OSC_XT = 3'd1,
    OSC_HS = 3'd2,
    OSC_EC = 3'd3,
    OSC_RC = 3'd4
  } osc_mode_e;

  // Crystal-type modes need the start-up timer before monitoring.
  function automatic logic needs_startup(input logic [2:0] m);
    return (m == OSC_LP) || (m == OSC_XT) || (m == OSC_HS);
  endfunction
endpackage

// File: rtl/fscm_sync.sv
module fscm_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2, s3;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
        s3 <= 1'b0;
      end else begin
        s1 <= din[i];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign rise[i] = s2 & ~s3;
  end
endmodule

// File: rtl/fscm_startup.sv
module fscm_startup #(
  parameter int CYCLES = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic wait_osc,
  input  logic ext_rise,
  output logic stable_o
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      cnt      <= '0;
      stable_o <= 1'b0;
    end else if (!stable_o) begin
      if (!wait_osc) begin
        stable_o <= 1'b1;
      end else if (ext_rise) begin
        if (cnt == LAST) begin
          stable_o <= 1'b1;
          cnt      <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fscm_detect.sv
module fscm_detect (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic smp_rise,
  input  logic ext_rise,
  output logic fail_o
);
  logic armed;

  // A sample edge arms the test; an external edge disarms it.
  // Still armed at the next sample edge means the oscillator is gone.
  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      armed  <= 1'b0;
      fail_o <= 1'b0;
    end else begin
      fail_o <= smp_rise & armed & ~ext_rise;
      if (smp_rise)      armed <= 1'b1;
      else if (ext_rise) armed <= 1'b0;
    end
  end
endmodule

// File: rtl/fscm_top.sv
module fscm_top
  import fscm_pkg::*;
#(
  parameter int STARTUP_CYCLES = 1024,
  parameter int FREQ_W         = 3,
  parameter int FREQ_RST       = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        osc_mode,
  input  logic              ext_clk,
  input  logic              smp_clk,
  input  logic              sleep_enter,
  input  logic              wake,
  input  logic              sel_wr,
  input  logic              sel_wdata,
  input  logic              freq_wr,
  input  logic [FREQ_W-1:0] freq_wdata,
  input  logic              flag_clr,
  output logic              use_int,
  output logic              failsafe,
  output logic              fail_flag,
  output logic              stable,
  output logic [FREQ_W-1:0] int_freq
);
  localparam int NSYNC = 2;

  logic [NSYNC-1:0] rises;
  logic ext_rise, smp_rise;
  logic asleep_q, scs_q;
  logic fail_pulse, clear_evt, mon_en;
  logic fs_d, scs_d;

  fscm_sync #(.W(NSYNC)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({smp_clk, ext_clk}),
    .rise(rises)
  );
  assign ext_rise = rises[0];
  assign smp_rise = rises[1];

  fscm_startup #(.CYCLES(STARTUP_CYCLES)) u_start (
    .clk     (clk),
    .rst     (rst),
    .hold    (sleep_enter | asleep_q),
    .wait_osc(needs_startup(osc_mode)),
    .ext_rise(ext_rise),
    .stable_o(stable)
  );

  assign clear_evt = sleep_enter | (sel_wr & (sel_wdata != scs_q));
  assign mon_en    = stable & ~asleep_q & ~failsafe & ~clear_evt;

  fscm_detect u_det (
    .clk     (clk),
    .rst     (rst),
    .enable  (mon_en),
    .smp_rise(smp_rise),
    .ext_rise(ext_rise),
    .fail_o  (fail_pulse)
  );

  assign fs_d  = clear_evt ? 1'b0 : (failsafe | fail_pulse);
  assign scs_d = sel_wr ? sel_wdata : scs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      asleep_q  <= 1'b0;
      scs_q     <= 1'b0;
      failsafe  <= 1'b0;
      fail_flag <= 1'b0;
      int_freq  <= FREQ_W'(FREQ_RST);
      use_int   <= 1'b1;
    end else begin
      if (sleep_enter) asleep_q <= 1'b1;
      else if (wake)   asleep_q <= 1'b0;
      scs_q    <= scs_d;
      failsafe <= fs_d;
      if (fail_pulse && !clear_evt) fail_flag <= 1'b1;
      else if (flag_clr && !failsafe) fail_flag <= 1'b0;
      if (freq_wr) int_freq <= freq_wdata;
      use_int <= scs_d | fs_d | ~stable;
    end
  end
endmodule

// File: rtl/fscm_chk.sv
module fscm_chk (
  input logic clk,
  input logic rst,
  input logic sleep_enter,
  input logic sel_wr,
  input logic freq_wr,
  input logic flag_clr,
  input logic use_int,
  input logic failsafe,
  input logic fail_flag,
  input logic stable
);
  a_r9_failsafe_selects_int: assert property (@(posedge clk) disable iff (rst)
    failsafe |-> use_int);

  a_r5_sleep_clears_failsafe: assert property (@(posedge clk) disable iff (rst)
    sleep_enter |=> !failsafe);

  a_r6_freq_keeps_failsafe: assert property (@(posedge clk) disable iff (rst)
    (freq_wr && failsafe && !sel_wr && !sleep_enter) |=> failsafe);

  a_r7_flag_held_in_failsafe: assert property (@(posedge clk) disable iff (rst)
    (fail_flag && failsafe) |=> fail_flag);

  a_r7_flag_falls_on_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(fail_flag) |-> ($past(flag_clr) && !$past(failsafe)));

  a_r4_fail_needs_stable: assert property (@(posedge clk) disable iff (rst)
    $rose(failsafe) |-> ($past(stable) && fail_flag));
endmodule

bind fscm_top fscm_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .sleep_enter(sleep_enter),
  .sel_wr     (sel_wr),
  .freq_wr    (freq_wr),
  .flag_clr   (flag_clr),
  .use_int    (use_int),
  .failsafe   (failsafe),
  .fail_flag  (fail_flag),
  .stable     (stable)
);

// File: tb/sim_fscm_top.sv
module sim_fscm_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic [2:0] osc_mode = 3'd1;
  logic ext_clk = 1'b0, smp_clk = 1'b0, ext_run = 1'b0;
  logic sleep_enter = 1'b0, wake = 1'b0, sel_wr = 1'b0, sel_wdata = 1'b0;
  logic freq_wr = 1'b0, flag_clr = 1'b0;
  logic [2:0] freq_wdata = 3'd0;
  logic use_int, failsafe, fail_flag, stable;
  logic [2:0] int_freq;
  int checks = 0, errors = 0;
  bit done = 0;

  fscm_top u0 (.*);

  always #(CLK_P/2) clk = ~clk;
  always begin #(3*CLK_P); if (ext_run) ext_clk = ~ext_clk; end
  always begin #(40*CLK_P); smp_clk = ~smp_clk; end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic wait_stable(input string req);
    int n = 0;
    while (!stable && n < 8000) begin cyc(1); n++; end
    chk(req, stable, 1);
  endtask

  task automatic t_reset;
    rst = 1'b1; cyc(3);
    chk("R1 use_int", use_int, 1);
    chk("R1 failsafe", failsafe, 0);
    chk("R1 fail_flag", fail_flag, 0);
    chk("R1 stable", stable, 0);
    chk("R1 int_freq", int_freq, 6);
    rst = 1'b0; cyc(2);
    chk("R1 stable after release", stable, 0);
  endtask

  task automatic t_xtal_startup;
    ext_run = 1'b1;
    cyc(1000);
    chk("R2 not yet stable", stable, 0);
    chk("R2 runs internal", use_int, 1);
    wait_stable("R2 stable");
    cyc(3);
    chk("R2 switched external", use_int, 0);
  endtask

  task automatic t_monitor_ok;
    cyc(600);
    chk("R4 no false failure", failsafe, 0);
  endtask

  task automatic t_fail;
    ext_run = 1'b0; cyc(300);
    chk("R4 failsafe", failsafe, 1);
    chk("R4 fail_flag", fail_flag, 1);
    chk("R9 internal in failsafe", use_int, 1);
  endtask

  task automatic t_freq;
    @(negedge clk); freq_wdata = 3'd2; pulse(freq_wr); cyc(2);
    chk("R6 int_freq", int_freq, 2);
    chk("R6 failsafe kept", failsafe, 1);
  endtask

  task automatic t_clr_ignored;
    pulse(flag_clr); cyc(2);
    chk("R7 clear ignored", fail_flag, 1);
  endtask

  task automatic t_sel_clear;
    @(negedge clk); sel_wdata = 1'b0; pulse(sel_wr); cyc(2);
    chk("R5 same select keeps", failsafe, 1);
    ext_run = 1'b1; cyc(10);
    @(negedge clk); sel_wdata = 1'b1; pulse(sel_wr); cyc(2);
    chk("R5 select change clears", failsafe, 0);
    chk("R9 forced internal", use_int, 1);
    chk("R7 flag still set", fail_flag, 1);
    pulse(flag_clr); cyc(2);
    chk("R7 flag cleared", fail_flag, 0);
    @(negedge clk); sel_wdata = 1'b0; pulse(sel_wr); cyc(3);
    chk("R9 back to external", use_int, 0);
  endtask

  task automatic t_sleep;
    ext_run = 1'b0; cyc(300);
    chk("R4 fails again", failsafe, 1);
    pulse(sleep_enter); cyc(2);
    chk("R5 sleep clears failsafe", failsafe, 0);
    chk("R8 sleep clears stable", stable, 0);
    chk("R8 flag sticky", fail_flag, 1);
    cyc(300);
    chk("R8 no monitor in sleep", failsafe, 0);
    pulse(wake); cyc(500);
    chk("R8 restart needs startup", stable, 0);
    chk("R8 no monitor before stable", failsafe, 0);
    chk("R2 internal during startup", use_int, 1);
    ext_run = 1'b1;
    wait_stable("R8 stable after wake");
  endtask

  task automatic t_ec_mode;
    ext_run = 1'b0; osc_mode = 3'd3; rst = 1'b1; cyc(3);
    rst = 1'b0; cyc(5);
    chk("R3 stable at once", stable, 1);
    chk("R3 external selected", use_int, 0);
    cyc(300);
    chk("R3 monitoring immediate", failsafe, 1);
    rst = 1'b1; cyc(2);
    chk("R5 reset clears failsafe", failsafe, 0);
    rst = 1'b0;
  endtask

  initial begin
    t_reset();
    t_xtal_startup();
    t_monitor_ok();
    t_fail();
    t_freq();
    t_clr_ignored();
    t_sel_clear();
    t_sleep();
    t_ec_mode();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000*CLK_P);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule